// File: doc/BRIEF.md
# Auto-Ranging Tachometer Period Meter

This block turns the pulse train of a tachogenerator into a period measurement that a speed loop can use. The raw input is synchronised and debounced. Its falling edges are then stamped with the value of a free-running timer whose clock is divided by a power of two. The timer wraps after a fixed number of ticks, and each wrap closes a measurement window. For every window that saw at least two accepted edges, the block publishes three values: the tick distance between the first and the last accepted edge, the number of intervals that distance spans, and the divider exponent in use. The receiver divides the tick count by the interval count and scales by the divider to get the period.

Two window contexts take turns. Each context has its own timestamps, interval index and divider exponent. The timer always runs on the exponent of the context that is currently collecting edges. A context that saw too few intervals slows its timer down for its next turn. A context that saw more intervals than the averaging depth speeds its timer up, and its window is cut short at once. A run of windows without a usable interval drives the published count to zero, which marks a stalled shaft.

Top module: `tacho_period_meter`

## Requirements
- R1: In reset, meas_count, meas_pulses and meas_psc are 0, meas_valid is low, and both contexts hold divider exponent PSC_MAX.
- R2: A low level on tacho_in shorter than FILT_LEN clock cycles does not reach edge detection.
- R3: Only high-to-low transitions of the filtered input are captured. Rising edges never add an interval.
- R4: With exponent p, the timer advances once every 2^p clocks and wraps after RELOAD+1 ticks. Each wrap closes the active window, so a window lasts (RELOAD+1)*2^p clocks when it is not cut short.
- R5: The first capture in a window sets both the start and the end stamp and sets the index to 0. A later capture is accepted only when its stamp is strictly greater than the end stamp. When accepted, it replaces the end stamp and raises the index by one.
- R6: A capture accepted when the index already equals AVG_N marks the window over-count. The window then closes on the next clock, the timer and divider restart from zero, and meas_pulses is published as AVG_N+1.
- R7: Closing an over-count window lowers that context's exponent by one, and never below 0.
- R8: Closing a window whose index is below AVG_N raises that context's exponent by one, and never above PSC_MAX. An index equal to AVG_N leaves the exponent unchanged.
- R9: The two contexts alternate on every close. Each keeps its own exponent, and the timer uses the exponent of the context that is collecting.
- R10: Closing a window with index above 0 publishes meas_count = end - start (modulo 2^CNT_W), meas_pulses and meas_psc, and clears the empty-window counter. Every other close increments that counter, which saturates. Once the counter has reached ERR_MAX, each such close publishes meas_count = 0 and leaves meas_pulses and meas_psc unchanged.
- R11: While en is low, the timer and divider hold their values, no window closes, and edges are ignored.
- R12: meas_valid is high for exactly one cycle for each update of the published values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low freezes the timer and ignores edges |
| tacho_in | input | 1 | Raw asynchronous tacho pulse input |
| meas_count | output | CNT_W | Ticks between first and last accepted edge; 0 on stall |
| meas_pulses | output | 8 | Intervals spanned, or AVG_N+1 after an over-count |
| meas_psc | output | $clog2(PSC_MAX+1) | Divider exponent used for meas_count |
| meas_valid | output | 1 | One-cycle strobe on each update |

## Verification
The bench drives a one-cycle glitch ahead of the real edges. If the filter were missing, the window would start early and report an extra interval. It drives one edge more than the averaging depth. A design without the forced restart would keep the window open for its full length, and one that dropped the speed-up would report the slow exponent in that context's next window. It runs a window with exactly AVG_N intervals inside a context that was already sped up. A design that used a less-than-or-equal test would report a slower exponent on that context's next turn. It checks three more things: that a disabled period stretches the window by exactly its length, that edges sent during that period leave no trace, and that the stall zero appears only on the third empty close after an accepted window.

// File: rtl/tacho_period_meter.sv
module tacho_period_meter #(
  parameter int CNT_W    = 16,
  parameter int RELOAD   = 999,
  parameter int PSC_MAX  = 6,
  parameter int AVG_N    = 8,
  parameter int ERR_MAX  = 4,
  parameter int FILT_LEN = 4,
  localparam int PSC_W   = $clog2(PSC_MAX + 1),
  localparam int DIV_W   = PSC_MAX + 1,
  localparam int ERR_W   = $clog2(ERR_MAX + 1),
  localparam int FLT_W   = $clog2(FILT_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tacho_in,
  output logic [CNT_W-1:0] meas_count,
  output logic [7:0]       meas_pulses,
  output logic [PSC_W-1:0] meas_psc,
  output logic             meas_valid
);
  localparam logic signed [7:0] IDX_EMPTY = -8'sd1;
  localparam logic signed [7:0] IDX_OVER  = 8'sd127;
  localparam logic signed [7:0] N_S       = 8'(AVG_N);

  // input conditioning
  logic sy1, sy2, flt, flt_d;
  logic [FLT_W-1:0] fcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= 1'b1; sy2 <= 1'b1; flt <= 1'b1; flt_d <= 1'b1;
      fcnt <= '0;
    end else begin
      sy1   <= tacho_in;
      sy2   <= sy1;
      flt_d <= flt;
      if (sy2 == flt) fcnt <= '0;
      else if (fcnt == FLT_W'(FILT_LEN - 1)) begin
        flt  <= sy2;
        fcnt <= '0;
      end else fcnt <= fcnt + 1'b1;
    end
  end

  wire fall = en & flt_d & ~flt;

  // window contexts and timer
  logic                    sel;
  logic [PSC_W-1:0]        psc     [2];
  logic [CNT_W-1:0]        t_start [2];
  logic [CNT_W-1:0]        t_end   [2];
  logic signed [7:0]       idx     [2];
  logic [DIV_W-1:0]        dcnt;
  logic [CNT_W-1:0]        tcnt;
  logic                    force_q;
  logic [ERR_W-1:0]        errs;

  wire [PSC_W-1:0] cur_psc = psc[sel];
  wire [DIV_W-1:0] dmax    = (DIV_W'(1) << cur_psc) - DIV_W'(1);
  wire tick  = en && (dcnt == dmax);
  wire wrap  = tick && (tcnt == CNT_W'(RELOAD));
  wire close = wrap || (en && force_q);
  wire cap   = fall && !close;

  wire signed [7:0] old = idx[sel];
  wire has_iv = old > 8'sd0;
  wire over   = old == IDX_OVER;
  wire under  = old < N_S;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt <= '0;
      tcnt <= '0;
    end else if (close) begin
      dcnt <= '0;
      tcnt <= '0;
    end else if (en) begin
      if (tick) begin
        dcnt <= '0;
        tcnt <= tcnt + 1'b1;
      end else dcnt <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel         <= 1'b0;
      force_q     <= 1'b0;
      errs        <= '0;
      meas_count  <= '0;
      meas_pulses <= '0;
      meas_psc    <= '0;
      meas_valid  <= 1'b0;
      for (int c = 0; c < 2; c++) begin
        psc[c]     <= PSC_W'(PSC_MAX);
        idx[c]     <= IDX_EMPTY;
        t_start[c] <= '0;
        t_end[c]   <= '0;
      end
    end else begin
      meas_valid <= 1'b0;
      if (close) begin
        force_q  <= 1'b0;
        idx[sel] <= IDX_EMPTY;
        sel      <= ~sel;
        if (has_iv) begin
          errs        <= '0;
          meas_valid  <= 1'b1;
          meas_psc    <= cur_psc;
          meas_pulses <= over ? 8'(AVG_N + 1) : $unsigned(old);
          meas_count  <= t_end[sel] - t_start[sel];
          if (over && cur_psc != '0) psc[sel] <= cur_psc - 1'b1;
        end else begin
          if (errs != ERR_W'(ERR_MAX)) errs <= errs + 1'b1;
          if (errs >= ERR_W'(ERR_MAX - 1)) begin
            meas_count <= '0;
            meas_valid <= 1'b1;
          end
        end
        if (under && cur_psc != PSC_W'(PSC_MAX)) psc[sel] <= cur_psc + 1'b1;
      end else if (cap) begin
        if (old == IDX_EMPTY) begin
          t_start[sel] <= tcnt;
          t_end[sel]   <= tcnt;
          idx[sel]     <= 8'sd0;
        end else if (!over && tcnt > t_end[sel]) begin
          t_end[sel] <= tcnt;
          if (under) idx[sel] <= old + 8'sd1;
          else begin
            idx[sel] <= IDX_OVER;
            force_q  <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tacho_period_meter_chk.sv
module tacho_period_meter_chk #(
  parameter int CNT_W   = 16,
  parameter int RELOAD  = 999,
  parameter int PSC_MAX = 6,
  parameter int AVG_N   = 8,
  localparam int PSC_W  = $clog2(PSC_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [CNT_W-1:0] tcnt,
  input logic [7:0]       meas_pulses,
  input logic [PSC_W-1:0] meas_psc,
  input logic             meas_valid
);
  assert_valid_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |=> !meas_valid);

  assert_psc_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    meas_psc <= PSC_W'(PSC_MAX));

  assert_pulses_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |-> (meas_pulses <= 8'(AVG_N + 1)));

  assert_timer_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= CNT_W'(RELOAD));

  assert_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(tcnt));
endmodule

bind tacho_period_meter tacho_period_meter_chk #(
  .CNT_W(CNT_W), .RELOAD(RELOAD), .PSC_MAX(PSC_MAX), .AVG_N(AVG_N)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tcnt(tcnt),
  .meas_pulses(meas_pulses), .meas_psc(meas_psc), .meas_valid(meas_valid)
);

// File: tb/tacho_period_meter_bench.sv
module tacho_period_meter_bench;
  localparam int CW = 8;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic tacho = 1'b1;
  logic [CW-1:0] meas_count;
  logic [7:0]    meas_pulses;
  logic [PW-1:0] meas_psc;
  logic          meas_valid;

  int checks = 0, failures = 0;
  int cyc = 0;
  int vcount = 0, vlast = 0;
  int s_count = 0, s_pulses = 0, s_psc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tacho_period_meter #(.CNT_W(CW), .RELOAD(49), .PSC_MAX(2), .AVG_N(3),
                       .ERR_MAX(3), .FILT_LEN(2)) u_tacho_period_meter (
    .clk(clk), .rst_n(rst_n), .en(en), .tacho_in(tacho),
    .meas_count(meas_count), .meas_pulses(meas_pulses),
    .meas_psc(meas_psc), .meas_valid(meas_valid));

  always @(negedge clk) if (meas_valid) begin
    vcount   <= vcount + 1;
    vlast    <= cyc;
    s_count  <= int'(meas_count);
    s_pulses <= int'(meas_pulses);
    s_psc    <= int'(meas_psc);
  end

  always @(posedge clk) if (cyc > 20000) begin
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=<20000", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask
  task automatic idle(input int n);
    repeat (n) step();
  endtask
  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask
  task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask
  task automatic train(input int k, input int spacing);
    repeat (k) begin
      tacho = 1'b0; idle(10);
      tacho = 1'b1; idle(spacing - 10);
    end
  endtask
  // wait for the next publish after n0 strobes; returns elapsed cycles from t0
  task automatic wait_next(input int n0, input int t0, input int limit, output int el);
    int k = 0;
    while (vcount == n0 && k < limit) begin step(); k++; end
    el = vlast - t0;
    idle(3);
    chk("R12", "strobe count", vcount, n0 + 1);
  endtask
  task automatic expect_res(input string req, input int c, input int p, input int s);
    chk(req, "count", s_count, c);
    chk(req, "pulses", s_pulses, p);
    chk(req, "psc", s_psc, s);
  endtask

  int t0, n0, el;

  task automatic t_reset();
    idle(4);
    chk("R1", "count", int'(meas_count), 0);
    chk("R1", "pulses", int'(meas_pulses), 0);
    chk("R1", "psc", int'(meas_psc), 0);
    chk("R1", "valid", int'(meas_valid), 0);
    rst_n = 1'b1;
    t0 = cyc;
  endtask

  task automatic t_stall_from_reset();
    n0 = vcount;
    wait_next(n0, t0, 1000, el);
    chk_rng("R10", "stall after three empty windows", el, 598, 602);
    expect_res("R10", 0, 0, 0);
  endtask

  task automatic t_normal_with_glitch();
    n0 = vcount; t0 = vlast;
    idle(5);
    tacho = 1'b0; step(); tacho = 1'b1;   // R2 one-cycle glitch
    idle(14);
    train(3, 40);
    wait_next(n0, t0, 400, el);
    chk_rng("R4", "window length p=2", el, 199, 201);
    expect_res("R2", 20, 2, 2);
    chk("R3", "rising edges not counted", s_pulses, 2);
    chk("R5", "count", s_count, 20);
  endtask

  task automatic t_overcount();
    n0 = vcount; t0 = vlast;
    idle(10);
    train(5, 20);
    wait_next(n0, t0, 400, el);
    chk_rng("R6", "early close", el, 85, 120);
    expect_res("R6", 20, 4, 2);
  endtask

  task automatic t_faster_context_at_n();
    // ctx1 empty (200 clocks), then ctx0 at exponent 1 (100 clocks)
    n0 = vcount; t0 = vlast;
    idle(210);
    train(4, 20);
    wait_next(n0, t0, 600, el);
    chk_rng("R4", "empty then p=1 window", el, 299, 301);
    expect_res("R7", 30, 3, 1);
  endtask

  task automatic t_slow_context();
    n0 = vcount; t0 = vlast;
    idle(10);
    train(3, 40);
    wait_next(n0, t0, 400, el);
    expect_res("R9", 20, 2, 2);
  endtask

  task automatic t_at_n_unchanged();
    n0 = vcount; t0 = vlast;
    idle(10);
    train(3, 20);
    wait_next(n0, t0, 400, el);
    chk_rng("R4", "window length p=1", el, 99, 101);
    expect_res("R8", 20, 2, 1);
  endtask

  task automatic t_disable();
    n0 = vcount; t0 = vlast;
    idle(5);
    en = 1'b0;
    idle(15);
    train(3, 40);
    idle(465);
    chk("R11", "no close while disabled", vcount, n0);
    en = 1'b1;
    idle(20);
    train(2, 40);
    wait_next(n0, t0, 600, el);
    chk_rng("R11", "window stretched by disable", el, 798, 802);
    expect_res("R11", 10, 1, 2);
  endtask

  task automatic t_raised_context();
    n0 = vcount; t0 = vlast;
    idle(10);
    train(3, 40);
    wait_next(n0, t0, 400, el);
    expect_res("R8", 20, 2, 2);
  endtask

  task automatic t_stall_after_data();
    n0 = vcount; t0 = vlast;
    wait_next(n0, t0, 800, el);
    chk_rng("R10", "counter cleared by data", el, 599, 601);
    expect_res("R10", 0, 2, 2);
    n0 = vcount; t0 = vlast;
    wait_next(n0, t0, 400, el);
    chk_rng("R10", "stall persists", el, 199, 201);
    chk("R10", "count held zero", s_count, 0);
  endtask

  initial begin
    t_reset();
    t_stall_from_reset();
    t_normal_with_glitch();
    t_overcount();
    t_faster_context_at_n();
    t_slow_context();
    t_at_n_unchanged();
    t_disable();
    t_raised_context();
    t_stall_after_data();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule